// File: doc/BRIEF.md
# Oversampled Serial Phase Picker

This block receives one serial video lane that has already been sampled three times per bit period. The three samples come from clock phases spaced 120 degrees apart. One sample of each phase arrives on every clock. The block keeps a 10-bit history for each phase and cuts the stream into 10-bit words. It emits one parallel word every ten clocks, taken from whichever phase it currently trusts.

Phase choice and word alignment are learned only while the data-enable input is low (blanking). During blanking the transmitter sends a small set of control characters. These are dense with transitions and easy to recognise. Each phase earns a point whenever its 10-bit window at a word boundary equals one of these characters. At the end of every evaluation window the phase with the most points becomes the source of output words. While data enable is high (active video), the chosen phase and all learning state are frozen until the next blanking interval. If blanking words keep arriving without any recognisable character, the word boundary is moved one bit later. A lock flag reports a stable boundary.

Top module: `serial_phase_picker`

## Requirements
- R1: While reset is asserted and after its release, `word_vld_o` and `lock_o` are 0 and `word_o` is all zeros, and phase 0 is the selected phase.
- R2: Each clock shifts one sample per phase into that phase's history. A word boundary falls on every tenth clock, the first one on the tenth rising edge after reset release. At a boundary `word_o` takes the ten most recent samples of the selected phase, with the earliest sample in bit 9, and `word_vld_o` is high for exactly the following cycle.
- R3: A window is a control character when it equals one of 10'b1101010100, 10'b0010101011, 10'b0101010100 or 10'b1010101011. Any other value, including all zeros, is not one.
- R4: A boundary sampled with `de_i` low is a blanking word. Over `EVAL_WORDS` blanking words (default 8) each phase counts its control-character hits. At the last word of the window the phase with the highest count becomes selected, and the lowest phase index wins a tie. If every count is zero the selection is kept. The word emitted at that last boundary still comes from the previous phase, and the new phase applies from the next word.
- R5: Words whose boundary sees `de_i` high neither advance the evaluation window nor alter the selection, the miss count or the hit run. Output words keep flowing from the selected phase.
- R6: After `MISS_LIMIT` (default 16) consecutive blanking words in which no phase holds a control character, the boundary slips one bit later. The word at the slipping boundary is still emitted, and the next boundary comes 11 clocks after it instead of 10.
- R7: `lock_o` rises at the boundary that completes `LOCK_RUN` (default 8) consecutive blanking words with a control character on some phase. It stays high through misses and active video, and falls in the same cycle as a slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| samp_i | input | 3 | One sample per phase this bit period; bit p is phase p (0, 120, 240 degrees) |
| de_i | input | 1 | Data enable; low marks blanking |
| word_o | output | 10 | Aligned word from the selected phase, earliest bit in bit 9 |
| word_vld_o | output | 1 | One-cycle strobe for each new word |
| lock_o | output | 1 | Word boundary is stable |

## Verification
The boundary slip and a word emission fall on the same clock edge. The lock flag also drops on that edge. The bench provokes this by feeding sixteen all-zero blanking words after a locked stretch. It then checks that the sixteenth word still reaches the scoreboard and that `lock_o` is low right after that boundary but high one word earlier. It also checks that the next strobe arrives exactly 11 clocks later. A single padding bit then realigns the stimulus, and the bench checks that every later word matches its expected value, which proves that the boundary moved by exactly one bit.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int WORD_BITS = 10;
  localparam int NUM_PH    = 3;
  localparam int SEL_W     = $clog2(NUM_PH);

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [SEL_W-1:0]     sel_t;

  localparam word_t CTRL_K0 = 10'b1101010100;
  localparam word_t CTRL_K1 = 10'b0010101011;
  localparam word_t CTRL_K2 = 10'b0101010100;
  localparam word_t CTRL_K3 = 10'b1010101011;

  function automatic logic is_ctrl(input word_t w);
    return (w == CTRL_K0) || (w == CTRL_K1) || (w == CTRL_K2) || (w == CTRL_K3);
  endfunction
endpackage

// File: rtl/sp_framer.sv
module sp_framer #(
  parameter int WBITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slip_i,
  output logic strobe_o
);
  localparam int CW = $clog2(WBITS);
  localparam logic [CW-1:0] LAST = CW'(WBITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_q, hold_d;

  always_comb begin
    strobe_o = (cnt_q == LAST) && !hold_q;
    hold_d   = slip_i;
    if (hold_q)
      cnt_d = cnt_q;
    else if (cnt_q == LAST)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WBITS)); // R2
  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R2
  AST_SLIP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i |-> strobe_o); // R6
  AST_HOLD_AFTER_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i |=> (hold_q && cnt_q == '0)); // R6
endmodule

// File: rtl/sp_scorer.sv
module sp_scorer #(
  parameter int NPH        = 3,
  parameter int SELW       = 2,
  parameter int EVAL_WORDS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blank_word_i,
  input  logic [NPH-1:0]  hit_i,
  output logic [SELW-1:0] sel_o
);
  localparam int HW = $clog2(EVAL_WORDS + 1);
  localparam int EW = $clog2(EVAL_WORDS);
  localparam logic [EW-1:0] EVAL_LAST = EW'(EVAL_WORDS - 1);

  logic [HW-1:0]   hits_q [NPH];
  logic [HW-1:0]   hits_d [NPH];
  logic [EW-1:0]   eval_q, eval_d;
  logic [SELW-1:0] sel_q, sel_d;
  logic [HW-1:0]   best_cnt;
  logic [SELW-1:0] best_idx;

  always_comb begin
    eval_d   = eval_q;
    sel_d    = sel_q;
    best_cnt = '0;
    best_idx = sel_q;
    for (int p = 0; p < NPH; p++) hits_d[p] = hits_q[p];
    if (blank_word_i) begin
      for (int p = 0; p < NPH; p++)
        hits_d[p] = hits_q[p] + {{(HW-1){1'b0}}, hit_i[p]};
      if (eval_q == EVAL_LAST) begin
        for (int p = 0; p < NPH; p++) begin
          if (hits_d[p] > best_cnt) begin
            best_cnt = hits_d[p];
            best_idx = SELW'(p);
          end
        end
        sel_d  = best_idx;
        eval_d = '0;
        for (int p = 0; p < NPH; p++) hits_d[p] = '0;
      end else begin
        eval_d = eval_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q <= '0;
      sel_q  <= '0;
      for (int p = 0; p < NPH; p++) hits_q[p] <= '0;
    end else begin
      eval_q <= eval_d;
      sel_q  <= sel_d;
      for (int p = 0; p < NPH; p++) hits_q[p] <= hits_d[p];
    end
  end

  assign sel_o = sel_q;

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q < SELW'(NPH)); // R4
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_word_i |=> $stable(sel_q)); // R5

  for (genvar g = 0; g < NPH; g++) begin : g_hit_bound
    AST_HITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      hits_q[g] <= HW'(eval_q)); // R4
  end
endmodule

// File: rtl/sp_lock.sv
module sp_lock #(
  parameter int MISS_LIMIT = 16,
  parameter int LOCK_RUN   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blank_word_i,
  input  logic any_hit_i,
  output logic slip_o,
  output logic lock_o
);
  localparam int MW = $clog2(MISS_LIMIT);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);
  localparam logic [RW-1:0] RUN_FULL  = RW'(LOCK_RUN);

  logic [MW-1:0] miss_q, miss_d;
  logic [RW-1:0] run_q, run_d;
  logic          lock_q, lock_d;

  always_comb begin
    miss_d = miss_q;
    run_d  = run_q;
    lock_d = lock_q;
    slip_o = 1'b0;
    if (blank_word_i) begin
      if (any_hit_i) begin
        miss_d = '0;
        if (run_q != RUN_FULL) run_d = run_q + 1'b1;
        if (run_d == RUN_FULL) lock_d = 1'b1;
      end else begin
        run_d = '0;
        if (miss_q == MISS_LAST) begin
          slip_o = 1'b1;
          miss_d = '0;
          lock_d = 1'b0;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      miss_q <= miss_d;
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  AST_SLIP_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |=> !lock_q); // R7
  AST_LOCK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(blank_word_i && any_hit_i)); // R7
  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q <= MISS_LAST); // R6
endmodule

// File: rtl/serial_phase_picker.sv
module serial_phase_picker #(
  parameter int EVAL_WORDS = 8,
  parameter int MISS_LIMIT = 16,
  parameter int LOCK_RUN   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  samp_i,
  input  logic        de_i,
  output logic [9:0]  word_o,
  output logic        word_vld_o,
  output logic        lock_o
);
  import sp_pkg::*;

  localparam int HIST = WORD_BITS - 1;

  logic [HIST-1:0]   hist_q [NUM_PH];
  word_t             win    [NUM_PH];
  logic [NUM_PH-1:0] hit;
  logic              strobe, blank_word, slip;
  sel_t              sel;
  word_t             word_sel, word_q, word_d;
  logic              vld_q;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    assign win[g] = {hist_q[g], samp_i[g]};
    assign hit[g] = is_ctrl(win[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[g] <= '0;
      else        hist_q[g] <= win[g][HIST-1:0];
    end
  end

  assign blank_word = strobe && !de_i;

  always_comb begin
    word_sel = '0;
    for (int p = 0; p < NUM_PH; p++)
      if (sel == SEL_W'(p)) word_sel = win[p];
    word_d = strobe ? word_sel : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= strobe;
    end
  end

  sp_framer #(.WBITS(WORD_BITS)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slip_i   (slip),
    .strobe_o (strobe)
  );

  sp_scorer #(.NPH(NUM_PH), .SELW(SEL_W), .EVAL_WORDS(EVAL_WORDS)) u_scorer (
    .clk          (clk),
    .rst_n        (rst_n),
    .blank_word_i (blank_word),
    .hit_i        (hit),
    .sel_o        (sel)
  );

  sp_lock #(.MISS_LIMIT(MISS_LIMIT), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .blank_word_i (blank_word),
    .any_hit_i    (|hit),
    .slip_o       (slip),
    .lock_o       (lock_o)
  );

  assign word_o     = word_q;
  assign word_vld_o = vld_q;

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(word_o)); // R2
  AST_SLIP_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> word_vld_o); // R6
endmodule

// File: tb/tb_serial_phase_picker.sv
module tb_serial_phase_picker;
  logic       clk;
  logic       rst_n;
  logic [2:0] samp_i;
  logic       de_i;
  logic [9:0] word_o;
  logic       word_vld_o;
  logic       lock_o;

  int   n_checks;
  int   n_errors;
  int   cyc;
  int   arm_after;
  int   gap_seen;
  logic done;

  logic [9:0] expq[$];
  string      tagq[$];

  localparam logic [9:0] KA = 10'b1101010100;
  localparam logic [9:0] KB = 10'b0010101011;
  localparam logic [9:0] KC = 10'b0101010100;
  localparam logic [9:0] KD = 10'b1010101011;
  localparam logic [9:0] Z  = 10'h000;

  serial_phase_picker dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .de_i(de_i),
    .word_o(word_o), .word_vld_o(word_vld_o), .lock_o(lock_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every word strobe
  always @(negedge clk) begin
    if (rst_n && word_vld_o) begin
      if (cyc > arm_after && gap_seen == 0) gap_seen = cyc;
      if (expq.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R2 unexpected word actual=%0h expected=none", word_o);
      end else begin
        logic [9:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, int'(word_o), int'(e));
      end
    end
  end

  task automatic send_bit(input logic b0, input logic b1, input logic b2, input logic de);
    samp_i = {b2, b1, b0};
    de_i   = de;
    @(negedge clk);
    #1;
  endtask

  task automatic send_word(input logic [9:0] w0, input logic [9:0] w1, input logic [9:0] w2,
                           input logic de, input logic [9:0] exp, input string tag);
    expq.push_back(exp);
    tagq.push_back(tag);
    for (int i = 9; i >= 0; i--) send_bit(w0[i], w1[i], w2[i], de);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; cyc = 0; arm_after = 1 << 30; gap_seen = 0; done = 1'b0;
    rst_n = 1'b0; samp_i = 3'b000; de_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 vld in reset", int'(word_vld_o), 0);
    chk("R1 lock in reset", int'(lock_o), 0);
    chk("R1 word in reset", int'(word_o), 0);
    rst_n = 1'b1;

    // phase 2 carries control characters, phase 0 (reset choice) is silent
    for (int k = 0; k < 8; k++) begin
      send_word(Z, Z, KA, 1'b0, Z, "R1 R4 old phase until window ends");
      if (k == 6) chk("R7 lock before 8th hit", int'(lock_o), 0);
    end
    chk("R7 lock after 8 hits", int'(lock_o), 1);
    for (int k = 0; k < 8; k++) send_word(Z, Z, KA, 1'b0, KA, "R2 R3 R4 phase 2 selected");

    // active line: phase 0 shows control chars but must not be chosen
    send_word(KC, Z, 10'h0F3, 1'b1, 10'h0F3, "R5 frozen in active");
    send_word(KC, Z, 10'h1C7, 1'b1, 10'h1C7, "R5 frozen in active");
    send_word(KC, Z, 10'h3E0, 1'b1, 10'h3E0, "R5 frozen in active");
    send_word(KC, Z, 10'h2B4, 1'b1, 10'h2B4, "R5 frozen in active");
    chk("R7 lock held in active", int'(lock_o), 1);

    // reselection toward phase 1
    for (int k = 0; k < 8; k++) send_word(Z, KD, Z, 1'b0, Z, "R4 phase 2 until window ends");
    // tie between phases 0 and 2: lowest index wins
    for (int k = 0; k < 8; k++) send_word(KB, Z, KB, 1'b0, Z, "R4 phase 1 until window ends");
    for (int k = 0; k < 8; k++) send_word(KB, Z, Z, 1'b0, KB, "R3 R4 tie picks phase 0");

    // long active line: must not count as misses
    for (int k = 0; k < 20; k++)
      send_word(10'h311 ^ 10'(k), Z, Z, 1'b1, 10'h311 ^ 10'(k), "R5 active words");
    chk("R5 R6 lock after long active", int'(lock_o), 1);

    // sixteen blanking words with nothing recognisable
    for (int k = 0; k < 16; k++) begin
      send_word(Z, Z, Z, 1'b0, Z, "R6 word emitted around slip");
      if (k == 14) chk("R6 R7 no slip before 16 misses", int'(lock_o), 1);
    end
    chk("R6 R7 lock drops on slip", int'(lock_o), 0);
    arm_after = cyc;

    // one padding bit realigns the stimulus with the later boundary
    send_bit(1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      send_word(KA, Z, Z, 1'b0, KA, "R6 realigned words");
      if (k == 0) chk("R6 next boundary 11 clocks after slip", gap_seen - arm_after, 11);
      if (k == 6) chk("R7 relock not yet", int'(lock_o), 0);
    end
    chk("R7 relock after 8 hits", int'(lock_o), 1);

    send_bit(1'b0, 1'b0, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 all expected words seen", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule